// File: doc/BRIEF.md
# Key Lifetime Guard

This block sits in the register front end of a cipher unit and protects the secret key held there. Software programs a 32-bit lifetime, writes the key words and asks the key-expansion engine to build a schedule. Once the engine reports that the schedule is built, the key counts as loaded and a countdown starts from the programmed lifetime. Each cycle without attention brings the key closer to being wiped.

Software keeps a key alive by polling the status word: every status read reloads the countdown. If polling stops and the countdown runs out, or if software sets the wipe bit in the control word, the block clears all key words. It then asks the engine to rebuild the schedule from the all-zero key, so no trace of the old key stays in the expansion state. The engine itself lies outside the block and is reached only through a request pulse and a done pulse.

Top module: `key_lifetime_guard`

## Requirements
- R1: After reset the status word (0x09) reads 1 (ready set, valid clear, loaded clear), the lifetime word reads 0, all key outputs are zero and both request pulses are low.
- R2: The lifetime word at 0x0b reads back exactly the 32-bit value last written to it.
- R3: Key words at 0x10..0x17 drive `key_out`, with word 0x10 in bits 255:224 and word 0x17 in bits 31:0. Key words read back as 0. The config word at 0x0a holds bit 0 (encrypt/decrypt, on `cfg_encdec`) and bit 1 (key length, on `cfg_keylen`) and reads back.
- R4: Writing control (0x08) with bit 0 set while ready gives a one-cycle `init_req` after that edge and clears ready and loaded. The `eng_done` pulse that answers it sets ready and loaded and loads the countdown with the lifetime. Bit 1 alone gives `next_req` and, on its done, sets valid.
- R5: Status bits are ready (bit 0), valid (bit 1) and loaded (bit 2). A status read while loaded reloads the countdown to the lifetime.
- R6: While loaded, the countdown drops by one each cycle. On the edge where it holds 1, all key words clear and loaded clears.
- R7: Writing control with bit 2 set wipes the key words at that edge, whatever the countdown holds.
- R8: A wipe clears ready, raises `init_req` for one cycle after the wipe edge, and leaves loaded clear after the engine's done pulse, while ready returns to 1.
- R9: A wipe wins over a status read or a request bit in the same cycle: the countdown is not reloaded and no other request is issued.
- R10: Writing the lifetime while loaded loads the countdown with the new value at that edge.
- R11: A lifetime of 0 disables expiry: a loaded key stays loaded.
- R12: Control bits are pulses that read back as 0. An init or next request made while ready is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| key_out | output | 256 | Key words to the engine |
| cfg_encdec | output | 1 | Encrypt/decrypt select |
| cfg_keylen | output | 1 | Key length select (0 = 128, 1 = 256 bits) |
| init_req | output | 1 | Key-expansion request pulse |
| next_req | output | 1 | Block-processing request pulse |
| eng_done | input | 1 | Engine completion pulse |

## Verification
The bench builds the block with its default widths (8-bit address, 32-bit words, eight key words, 32-bit lifetime). It programs lifetimes of a few to a few hundred cycles at run time, so expiry, keep-alive polling and a mid-flight lifetime change all happen within a short run. An engine stand-in answers every request after four cycles. This lets the wipe-triggered zero-key rebuild and the ready/loaded sequence around it be followed edge by edge. The bench finds the cycle before expiry from its own model and places a status read there, to reach the ping-versus-expiry collision.

// File: rtl/key_lifetime_guard.sv
module key_lifetime_guard #(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int NKEY   = 8,
  parameter int LIFE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_cs,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic [DW*NKEY-1:0] key_out,
  output logic               cfg_encdec,
  output logic               cfg_keylen,
  output logic               init_req,
  output logic               next_req,
  input  logic               eng_done
);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h08);
  localparam logic [AW-1:0] A_STAT = AW'(8'h09);
  localparam logic [AW-1:0] A_CFG  = AW'(8'h0a);
  localparam logic [AW-1:0] A_LIFE = AW'(8'h0b);
  localparam logic [AW-1:0] A_KEY  = AW'(8'h10);

  typedef enum logic [1:0] {OP_NONE, OP_INIT, OP_WIPE, OP_NEXT} op_t;

  op_t               op_q;
  logic              ready_q, valid_q, loaded_q;
  logic [LIFE_W-1:0] life_q, ctr_q;
  logic [DW-1:0]     key_q [NKEY];

  wire wr       = bus_cs & bus_we;
  wire rd       = bus_cs & ~bus_we;
  wire wr_ctrl  = wr && bus_addr == A_CTRL;
  wire wr_life  = wr && bus_addr == A_LIFE;
  wire ping     = rd && bus_addr == A_STAT;
  wire expire   = loaded_q && ctr_q == LIFE_W'(1);
  wire wipe     = expire | (wr_ctrl & bus_wdata[2]);
  wire go_init  = wr_ctrl & bus_wdata[0] & ready_q & ~wipe;
  wire go_next  = wr_ctrl & bus_wdata[1] & ~bus_wdata[0] & ready_q & ~wipe;
  wire done     = eng_done && op_q != OP_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n)                       ctr_q <= '0;
    else if (wipe)                    ctr_q <= '0;
    else if (done && op_q == OP_INIT) ctr_q <= life_q;
    else if (loaded_q && wr_life)     ctr_q <= bus_wdata[LIFE_W-1:0];
    else if (loaded_q && ping)        ctr_q <= life_q;
    else if (loaded_q && ctr_q != '0) ctr_q <= ctr_q - LIFE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      life_q     <= '0;
      cfg_encdec <= 1'b0;
      cfg_keylen <= 1'b0;
    end else begin
      if (wr_life) life_q <= bus_wdata[LIFE_W-1:0];
      if (wr && bus_addr == A_CFG) {cfg_keylen, cfg_encdec} <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NKEY; i++) begin
      if (!rst_n || wipe)                      key_q[i] <= '0;
      else if (wr && bus_addr == A_KEY + AW'(i)) key_q[i] <= bus_wdata;
    end
  end

  for (genvar g = 0; g < NKEY; g++) begin : g_key
    assign key_out[DW*(NKEY-g)-1 -: DW] = key_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q  <= 1'b1;
      valid_q  <= 1'b0;
      loaded_q <= 1'b0;
      init_req <= 1'b0;
      next_req <= 1'b0;
      op_q     <= OP_NONE;
    end else if (wipe) begin
      ready_q  <= 1'b0;
      valid_q  <= 1'b0;
      loaded_q <= 1'b0;
      init_req <= 1'b1;
      next_req <= 1'b0;
      op_q     <= OP_WIPE;
    end else begin
      init_req <= go_init;
      next_req <= go_next;
      if (go_init) begin
        ready_q  <= 1'b0;
        valid_q  <= 1'b0;
        loaded_q <= 1'b0;
        op_q     <= OP_INIT;
      end else if (go_next) begin
        ready_q <= 1'b0;
        valid_q <= 1'b0;
        op_q    <= OP_NEXT;
      end else if (done) begin
        ready_q <= 1'b1;
        if (op_q == OP_INIT) loaded_q <= 1'b1;
        if (op_q == OP_NEXT) valid_q  <= 1'b1;
        op_q <= OP_NONE;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STAT:  bus_rdata = DW'({loaded_q, valid_q, ready_q});
      A_CFG:   bus_rdata = DW'({cfg_keylen, cfg_encdec});
      A_LIFE:  bus_rdata = DW'(life_q);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/key_lifetime_guard_chk.sv
module key_lifetime_guard_chk #(
  parameter int AW     = 8,
  parameter int KB     = 256,
  parameter int LIFE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_cs,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic              loaded,
  input logic              ready,
  input logic              wipe,
  input logic              init_req,
  input logic              eng_done,
  input logic [LIFE_W-1:0] ctr,
  input logic [LIFE_W-1:0] life,
  input logic [KB-1:0]     key_out
);
  assert_wipe_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (key_out == '0 && !loaded));

  assert_wipe_rebuild_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (init_req && !ready));

  assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && ctr > LIFE_W'(1) && !bus_cs) |=> ctr == $past(ctr) - LIFE_W'(1));

  assert_loaded_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded) |-> $past(eng_done));

  assert_ping_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && !wipe && bus_cs && !bus_we && bus_addr == AW'(8'h09)) |=> ctr == $past(life));

  assert_zero_life_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && ctr == '0 && !bus_cs) |=> loaded);
endmodule

bind key_lifetime_guard key_lifetime_guard_chk #(.AW(AW), .KB(DW*NKEY), .LIFE_W(LIFE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
  .loaded(loaded_q), .ready(ready_q), .wipe(wipe), .init_req(init_req),
  .eng_done(eng_done), .ctr(ctr_q), .life(life_q), .key_out(key_out)
);

// File: tb/test_key_lifetime_guard.sv
module test_key_lifetime_guard;
  localparam int CLK_PERIOD = 10;
  localparam int DONE_LAT   = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_cs = 1'b0, bus_we = 1'b0;
  logic [7:0]   bus_addr = 8'h00;
  logic [31:0]  bus_wdata = 32'h0;
  logic [31:0]  bus_rdata;
  logic [255:0] key_out;
  logic         cfg_encdec, cfg_keylen, init_req, next_req;
  logic         eng_done = 1'b0;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  key_lifetime_guard i_key_lifetime_guard (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_out(key_out),
    .cfg_encdec(cfg_encdec), .cfg_keylen(cfg_keylen), .init_req(init_req),
    .next_req(next_req), .eng_done(eng_done)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit          m_ready, m_valid, m_loaded, m_enc, m_klen, m_init, m_next;
  int          m_op;
  logic [31:0] m_ctr, m_life;
  logic [31:0] m_key [8];
  bit          t_wr, t_rd, t_wipe, t_si, t_sn, t_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ready = 1; m_valid = 0; m_loaded = 0; m_enc = 0; m_klen = 0;
      m_init = 0; m_next = 0; m_op = 0; m_ctr = 0; m_life = 0;
      for (int k = 0; k < 8; k++) m_key[k] = 0;
    end else begin
      t_wr   = bus_cs && bus_we;
      t_rd   = bus_cs && !bus_we;
      t_wipe = (m_loaded && m_ctr == 1) || (t_wr && bus_addr == 8'h08 && bus_wdata[2]);
      t_si   = t_wr && bus_addr == 8'h08 && bus_wdata[0] && m_ready && !t_wipe;
      t_sn   = t_wr && bus_addr == 8'h08 && bus_wdata[1] && !bus_wdata[0] && m_ready && !t_wipe;
      t_done = eng_done && m_op != 0;
      if (t_wipe) m_ctr = 0;
      else if (t_done && m_op == 1) m_ctr = m_life;
      else if (m_loaded && t_wr && bus_addr == 8'h0b) m_ctr = bus_wdata;
      else if (m_loaded && t_rd && bus_addr == 8'h09) m_ctr = m_life;
      else if (m_loaded && m_ctr != 0) m_ctr = m_ctr - 1;
      if (t_wr && bus_addr == 8'h0b) m_life = bus_wdata;
      if (t_wr && bus_addr == 8'h0a) begin m_enc = bus_wdata[0]; m_klen = bus_wdata[1]; end
      for (int k = 0; k < 8; k++)
        if (t_wipe) m_key[k] = 0;
        else if (t_wr && bus_addr == 8'h10 + k) m_key[k] = bus_wdata;
      if (t_wipe) begin
        m_ready = 0; m_valid = 0; m_loaded = 0; m_op = 2; m_init = 1; m_next = 0;
      end else begin
        m_init = t_si; m_next = t_sn;
        if (t_si) begin m_ready = 0; m_valid = 0; m_loaded = 0; m_op = 1; end
        else if (t_sn) begin m_ready = 0; m_valid = 0; m_op = 3; end
        else if (t_done) begin
          m_ready = 1;
          if (m_op == 1) m_loaded = 1;
          if (m_op == 3) m_valid = 1;
          m_op = 0;
        end
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h09:   return {29'h0, m_loaded, m_valid, m_ready};
      8'h0a:   return {30'h0, m_klen, m_enc};
      8'h0b:   return m_life;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [255:0] m_keyvec();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[255-32*k -: 32] = m_key[k];
    return v;
  endfunction

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3 key_out",  key_out, m_keyvec());
      chk("R2 rdata",    bus_rdata, m_read(bus_addr));
      chk("R8 init_req", init_req, m_init);
      chk("R4 next_req", next_req, m_next);
      chk("R3 cfg",      {cfg_keylen, cfg_encdec}, {m_klen, m_enc});
    end
  end

  // engine stand-in
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && (init_req || next_req)) begin
        repeat (DONE_LAT - 1) @(posedge clk);
        #1 eng_done = 1'b1;
        @(posedge clk);
        #1 eng_done = 1'b0;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_cs = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    bus_cs = 1; bus_we = 0; bus_addr = a;
    #3 d = bus_rdata;
    @(posedge clk); #1;
    bus_cs = 0;
  endtask

  task automatic load_key(input logic [31:0] base);
    for (int k = 0; k < 8; k++) bus_wr(8'h10 + 8'(k), base + 32'(k));
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);

    bus_rd(8'h09, d); chk("R1 status after reset", d, 32'h1);
    bus_rd(8'h0b, d); chk("R1 lifetime after reset", d, 32'h0);
    chk("R1 key after reset", key_out, 256'h0);

    bus_wr(8'h0b, 32'h1234abcd);
    bus_rd(8'h0b, d); chk("R2 lifetime readback", d, 32'h1234abcd);

    load_key(32'ha0000000);
    bus_wr(8'h0a, 32'h3);
    bus_rd(8'h10, d); chk("R3 key word reads zero", d, 32'h0);
    bus_rd(8'h0a, d); chk("R3 config readback", d, 32'h3);
    chk("R3 key word order", key_out[255:224], 32'ha0000000);
    chk("R3 key word order low", key_out[31:0], 32'ha0000007);

    bus_wr(8'h0b, 32'd20);
    bus_wr(8'h08, 32'h1);
    bus_wr(8'h08, 32'h1);
    bus_rd(8'h09, d); chk("R12 busy status", d, 32'h0);
    bus_rd(8'h08, d); chk("R12 control reads zero", d, 32'h0);
    idle(8);
    bus_rd(8'h09, d); chk("R4 loaded after init", d, 32'h5);

    for (int p = 0; p < 5; p++) begin
      idle(10);
      bus_rd(8'h09, d); chk("R5 ping keeps loaded", d[2], 1'b1);
    end
    chk("R5 key intact", key_out[255:224], 32'ha0000000);

    idle(30);
    chk("R6 key wiped on expiry", key_out, 256'h0);
    bus_rd(8'h09, d); chk("R8 zero key not loaded", d, 32'h1);

    load_key(32'hb0000000);
    bus_wr(8'h08, 32'h1);
    idle(8);
    bus_rd(8'h09, d); chk("R4 loaded again", d, 32'h5);
    bus_wr(8'h08, 32'h4);
    chk("R7 forced wipe", key_out, 256'h0);
    bus_rd(8'h09, d); chk("R8 ready low during rebuild", d, 32'h0);
    idle(8);
    bus_rd(8'h09, d); chk("R8 ready after rebuild", d, 32'h1);

    bus_wr(8'h0b, 32'd200);
    load_key(32'hc0000000);
    bus_wr(8'h08, 32'h1);
    idle(8);
    bus_wr(8'h0b, 32'd6);
    idle(3);
    bus_rd(8'h09, d); chk("R10 still loaded", d[2], 1'b1);
    idle(12);
    chk("R10 new lifetime expired", key_out, 256'h0);
    bus_rd(8'h09, d); chk("R10 status after expiry", d, 32'h1);

    bus_wr(8'h0b, 32'd12);
    load_key(32'hd0000000);
    bus_wr(8'h08, 32'h1);
    idle(8);
    while (m_ctr != 32'd1) idle(1);
    bus_rd(8'h09, d); chk("R9 status at expiry edge", d[2], 1'b1);
    chk("R9 wipe wins over ping", key_out, 256'h0);
    idle(8);
    bus_rd(8'h09, d); chk("R9 not reloaded", d, 32'h1);

    bus_wr(8'h0b, 32'd0);
    load_key(32'he0000000);
    bus_wr(8'h08, 32'h1);
    idle(100);
    bus_rd(8'h09, d); chk("R11 zero lifetime keeps key", d, 32'h5);
    chk("R11 key intact", key_out[31:0], 32'he0000007);

    bus_wr(8'h08, 32'h2);
    idle(8);
    bus_rd(8'h09, d); chk("R4 valid after next", d, 32'h7);
    bus_wr(8'h08, 32'h6);
    chk("R9 wipe wins over next", next_req, 1'b0);
    idle(8);
    bus_rd(8'h09, d); chk("R7 status after forced wipe", d, 32'h1);

    idle(2);
    summary();
  end
endmodule